// File: doc/BRIEF.md
# Boundary-Scan Cells for Bidirectional and Input-Only Pins

This block holds the boundary-scan register cells for a group of pins and links them into one serial chain. Each bidirectional pin has two cells, one for its output data and one for its driver enable. Each cell has a capture/shift stage and a separate update stage. Each input-only pin has one reduced cell with a capture/shift stage only. A test access port controller, which sits outside this block, drives the shift-select, DR clock enable, update strobe and external-test controls. The bench drives these controls directly.

In normal operation the pins carry the core's data and enable. In external-test mode each bidirectional pin takes its driven value and its enable from the update stage of its two cells. Two overrides, one high-impedance/programming-mode input and one active-low test output-enable, turn off every driver whatever the data path selects. Every stage runs on one clock. The DR clock and the update strobe are single-cycle enables on that clock.

Top module: `bsc_pin_chain`

## Requirements
- R1: While `rst_n` is low, every shift stage and every update stage is 0. So `scan_out` is 0, and with `ext_test`=1 every `pad_out` and `pad_oe` bit is 0.
- R2: On a clock edge with `dr_clk_en`=1 and `shift_dr`=0, each cell loads its functional value. The data cell of pin k loads `core_out[k]`, the enable cell of pin k loads `core_oe[k]`, and input-only cell j loads `in_pin[j]`.
- R3: On a clock edge with `dr_clk_en`=1 and `shift_dr`=1, the chain moves one place toward `scan_out`, and `scan_in` enters the first cell. The chain order from `scan_in` is: pin 0 data, pin 0 enable, pin 1 data, pin 1 enable, and so on, then input-only cells 0, 1, and so on. `scan_out` shows the last cell.
- R4: Each update stage loads the value its shift stage held before the edge, and only on an edge with `dr_upd_en`=1. Between updates the values driven to the pins stay stable while new bits shift through. This includes an edge that shifts and updates at once.
- R5: With `ext_test`=1, `pad_out[k]` and the pre-override enable of pin k come from the update stages of pin k's data cell and enable cell. With `ext_test`=0 they follow `core_out[k]` and `core_oe[k]`.
- R6: With `force_hiz`=1, every `pad_oe` bit is 0 in either mode, and `pad_out` still carries the selected data.
- R7: With `test_oe_n`=0, every `pad_oe` bit is 0 in either mode.
- R8: On an edge with `dr_clk_en`=0, no shift stage changes, whatever `shift_dr` and `scan_in` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every scan stage |
| rst_n | input | 1 | Asynchronous clear of all scan stages, active low |
| dr_clk_en | input | 1 | DR clock enable: capture or shift on this edge |
| shift_dr | input | 1 | 1 selects the serial path, 0 selects capture |
| dr_upd_en | input | 1 | Update strobe: shift stages copied to update stages |
| ext_test | input | 1 | Pins driven from the update stages |
| force_hiz | input | 1 | High-impedance/programming-mode override of all drivers |
| test_oe_n | input | 1 | Active-low test output enable; low disables all drivers |
| scan_in | input | 1 | Serial data into the first cell |
| core_out | input | N_BIDIR | Core data for each bidirectional pin |
| core_oe | input | N_BIDIR | Core driver enable for each bidirectional pin |
| in_pin | input | N_INPUT | Values seen on the input-only pins |
| scan_out | output | 1 | Serial data from the last cell |
| pad_out | output | N_BIDIR | Data to each pin driver |
| pad_oe | output | N_BIDIR | Enable to each pin driver, 1 drives |

## Verification
On every clock the assertions check these properties: the chain moves by exactly one place on a shift, the shift stages hold when the DR clock is idle, the update stages change only on the strobe and then take the pre-edge chain contents, both driver overrides keep every enable low, and in external-test mode the pins show the update stages. The bench scenarios cover what the assertions cannot see. These are the capture of functional values into the right chain positions and the bit order at `scan_out` over every 5-bit pattern, the core pass-through in normal mode, the outcome of an edge that shifts and updates together, and the clearing done by a reset in the middle of a run.

// File: rtl/bsc_pkg.sv
`timescale 1ns/1ps
package bsc_pkg;
  // Number of cells in the chain: two per bidirectional pin, one per input-only pin.
  function automatic int chain_len(input int n_bidir, input int n_input);
    return 2 * n_bidir + n_input;
  endfunction

  // Chain position of the data cell (sel_oe=0) or enable cell (sel_oe=1) of a pin.
  function automatic int bidir_pos(input int pin, input logic sel_oe);
    return 2 * pin + int'(sel_oe);
  endfunction

  // Value sent to the driver, chosen by the test-mode select.
  function automatic logic pick_data(input logic test_sel, input logic upd_v,
                                     input logic core_v);
    return test_sel ? upd_v : core_v;
  endfunction

  // Driver enable after both global overrides.
  function automatic logic gate_enable(input logic pre_en, input logic hiz,
                                       input logic toe_n);
    return pre_en & ~hiz & toe_n;
  endfunction
endpackage

// File: rtl/bsc_io_cell.sv
`timescale 1ns/1ps
module bsc_io_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_sel,
  input  logic upd_en,
  input  logic func_in,
  input  logic ser_in,
  output logic shift_q,
  output logic upd_q
);
  logic next_shift;

  assign next_shift = shift_sel ? ser_in : func_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      if (cap_en) shift_q <= next_shift;
      if (upd_en) upd_q   <= shift_q;
    end
  end
endmodule

// File: rtl/bsc_in_cell.sv
`timescale 1ns/1ps
module bsc_in_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_sel,
  input  logic func_in,
  input  logic ser_in,
  output logic shift_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shift_q <= 1'b0;
    else if (cap_en) shift_q <= shift_sel ? ser_in : func_in;
  end
endmodule

// File: rtl/bsc_pin_drive.sv
`timescale 1ns/1ps
module bsc_pin_drive (
  input  logic test_sel,
  input  logic hiz,
  input  logic toe_n,
  input  logic core_d,
  input  logic core_en,
  input  logic upd_d,
  input  logic upd_en_bit,
  output logic drv_d,
  output logic drv_en
);
  logic pre_en;

  assign drv_d  = bsc_pkg::pick_data(test_sel, upd_d, core_d);
  assign pre_en = bsc_pkg::pick_data(test_sel, upd_en_bit, core_en);
  assign drv_en = bsc_pkg::gate_enable(pre_en, hiz, toe_n);
endmodule

// File: rtl/bsc_pin_chain.sv
`timescale 1ns/1ps
module bsc_pin_chain #(
  parameter int N_BIDIR = 2,
  parameter int N_INPUT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dr_clk_en,
  input  logic               shift_dr,
  input  logic               dr_upd_en,
  input  logic               ext_test,
  input  logic               force_hiz,
  input  logic               test_oe_n,
  input  logic               scan_in,
  input  logic [N_BIDIR-1:0] core_out,
  input  logic [N_BIDIR-1:0] core_oe,
  input  logic [N_INPUT-1:0] in_pin,
  output logic               scan_out,
  output logic [N_BIDIR-1:0] pad_out,
  output logic [N_BIDIR-1:0] pad_oe
);
  localparam int CHAIN_LEN = bsc_pkg::chain_len(N_BIDIR, N_INPUT);
  localparam int UPD_LEN   = 2 * N_BIDIR;

  // Named internal state, brought out for the checker.
  logic [CHAIN_LEN-1:0] sr_chain;
  logic [UPD_LEN-1:0]   upd_chain;
  logic [CHAIN_LEN-1:0] chain_in;

  assign chain_in = {sr_chain[CHAIN_LEN-2:0], scan_in};
  assign scan_out = sr_chain[CHAIN_LEN-1];

  for (genvar k = 0; k < N_BIDIR; k++) begin : g_bidir
    localparam int PD = bsc_pkg::bidir_pos(k, 1'b0);
    localparam int PE = bsc_pkg::bidir_pos(k, 1'b1);

    bsc_io_cell u_data (
      .clk(clk), .rst_n(rst_n), .cap_en(dr_clk_en), .shift_sel(shift_dr),
      .upd_en(dr_upd_en), .func_in(core_out[k]), .ser_in(chain_in[PD]),
      .shift_q(sr_chain[PD]), .upd_q(upd_chain[PD])
    );

    bsc_io_cell u_enab (
      .clk(clk), .rst_n(rst_n), .cap_en(dr_clk_en), .shift_sel(shift_dr),
      .upd_en(dr_upd_en), .func_in(core_oe[k]), .ser_in(chain_in[PE]),
      .shift_q(sr_chain[PE]), .upd_q(upd_chain[PE])
    );

    bsc_pin_drive u_drive (
      .test_sel(ext_test), .hiz(force_hiz), .toe_n(test_oe_n),
      .core_d(core_out[k]), .core_en(core_oe[k]),
      .upd_d(upd_chain[PD]), .upd_en_bit(upd_chain[PE]),
      .drv_d(pad_out[k]), .drv_en(pad_oe[k])
    );
  end

  for (genvar j = 0; j < N_INPUT; j++) begin : g_inonly
    localparam int PI = UPD_LEN + j;

    bsc_in_cell u_in (
      .clk(clk), .rst_n(rst_n), .cap_en(dr_clk_en), .shift_sel(shift_dr),
      .func_in(in_pin[j]), .ser_in(chain_in[PI]), .shift_q(sr_chain[PI])
    );
  end
endmodule

// File: rtl/bsc_pin_chain_chk.sv
`timescale 1ns/1ps
module bsc_pin_chain_chk #(
  parameter int N_BIDIR = 2,
  parameter int N_INPUT = 1
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic                                          dr_clk_en,
  input logic                                          shift_dr,
  input logic                                          dr_upd_en,
  input logic                                          ext_test,
  input logic                                          force_hiz,
  input logic                                          test_oe_n,
  input logic                                          scan_in,
  input logic [N_BIDIR-1:0]                            pad_out,
  input logic [N_BIDIR-1:0]                            pad_oe,
  input logic [bsc_pkg::chain_len(N_BIDIR,N_INPUT)-1:0] sr_chain,
  input logic [2*N_BIDIR-1:0]                          upd_chain
);
  localparam int L = bsc_pkg::chain_len(N_BIDIR, N_INPUT);

  AST_SHIFT_ONE_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_clk_en && shift_dr) |=> sr_chain == {$past(sr_chain[L-2:0]), $past(scan_in)}); // R3

  AST_HOLD_WITHOUT_DR_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_clk_en |=> $stable(sr_chain)); // R8

  AST_UPDATE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_upd_en |=> $stable(upd_chain)); // R4

  AST_UPDATE_TAKES_PRE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    dr_upd_en |=> upd_chain == $past(sr_chain[2*N_BIDIR-1:0])); // R4

  AST_HIZ_DISABLES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    force_hiz |-> pad_oe == '0); // R6

  AST_TOE_LOW_DISABLES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !test_oe_n |-> pad_oe == '0); // R7

  for (genvar k = 0; k < N_BIDIR; k++) begin : g_pin
    AST_EXTEST_DATA_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_test |-> pad_out[k] == upd_chain[2*k]); // R5

    AST_EXTEST_ENABLE_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_test && !force_hiz && test_oe_n) |-> pad_oe[k] == upd_chain[2*k+1]); // R5
  end
endmodule

bind bsc_pin_chain bsc_pin_chain_chk #(.N_BIDIR(N_BIDIR), .N_INPUT(N_INPUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .dr_clk_en(dr_clk_en), .shift_dr(shift_dr),
  .dr_upd_en(dr_upd_en), .ext_test(ext_test), .force_hiz(force_hiz),
  .test_oe_n(test_oe_n), .scan_in(scan_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .sr_chain(sr_chain), .upd_chain(upd_chain)
);

// File: tb/test_bsc_pin_chain.sv
`timescale 1ns/1ps
module test_bsc_pin_chain;
  logic clk = 1'b0;
  logic rst_n, dr_clk_en, shift_dr, dr_upd_en, ext_test, force_hiz, test_oe_n, scan_in;
  logic [1:0] core_out, core_oe;
  logic [0:0] in_pin;
  logic scan_out;
  logic [1:0] pad_out, pad_oe;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bsc_pin_chain #(.N_BIDIR(2), .N_INPUT(1)) i_bsc_pin_chain (
    .clk(clk), .rst_n(rst_n), .dr_clk_en(dr_clk_en), .shift_dr(shift_dr),
    .dr_upd_en(dr_upd_en), .ext_test(ext_test), .force_hiz(force_hiz),
    .test_oe_n(test_oe_n), .scan_in(scan_in), .core_out(core_out),
    .core_oe(core_oe), .in_pin(in_pin), .scan_out(scan_out),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock edge with the given controls; returns 2 ns after the edge.
  task automatic step(input logic c, input logic s, input logic u, input logic si);
    dr_clk_en = c; shift_dr = s; dr_upd_en = u; scan_in = si;
    @(posedge clk); #2;
    dr_clk_en = 0; shift_dr = 0; dr_upd_en = 0;
  endtask

  // Read the chain out (first bit read = last cell) while feeding w_in bit 0 first.
  task automatic scan(input int w_in, output int w_out);
    w_out = int'(scan_out);
    for (int i = 0; i < 5; i++) begin
      step(1, 1, 0, w_in[i]);
      if (i < 4) w_out = w_out | (int'(scan_out) << (i + 1));
    end
  endtask

  // After word w is fed in and updated: data0=w[4], en0=w[3], data1=w[2], en1=w[1].
  function automatic int exp_dat(input int w);
    return ((w >> 4) & 1) | (((w >> 2) & 1) << 1);
  endfunction
  function automatic int exp_oe(input int w);
    return ((w >> 3) & 1) | (((w >> 1) & 1) << 1);
  endfunction

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int got;
    rst_n = 0; dr_clk_en = 0; shift_dr = 0; dr_upd_en = 0; ext_test = 1;
    force_hiz = 0; test_oe_n = 1; scan_in = 0; core_out = 2'b11; core_oe = 2'b11; in_pin = 1'b1;
    #12;
    check("R1 scan_out in reset", int'(scan_out), 0);
    check("R1 pad_out in reset", int'(pad_out), 0);
    check("R1 pad_oe in reset", int'(pad_oe), 0);
    rst_n = 1;
    #5;

    // R2/R3/R5 sweep: capture every pattern, read it out, load its complement, update.
    for (int v = 0; v < 32; v++) begin
      int cap_exp;
      core_out = v[1:0]; core_oe = v[3:2]; in_pin = v[4];
      // cap bit0=in_pin, bit1=oe1, bit2=out1, bit3=oe0, bit4=out0
      cap_exp = ((v >> 4) & 1) | (((v >> 3) & 1) << 1) | (((v >> 1) & 1) << 2)
              | (((v >> 2) & 1) << 3) | ((v & 1) << 4);
      step(1, 0, 0, 0);
      scan(31 - v, got);
      check("R2 R3 captured word order", got, cap_exp);
      step(0, 0, 1, 0);
      check("R5 extest pad_out from update", int'(pad_out), exp_dat(31 - v));
      check("R5 extest pad_oe from update", int'(pad_oe), exp_oe(31 - v));
    end

    // R4: shifting new bits leaves driven values alone until the strobe.
    begin
      int w2 = 5'b10101;
      int w_old = 31 - 31;
      for (int i = 0; i < 5; i++) begin
        step(1, 1, 0, w2[i]);
        check("R4 pad_out held while shifting", int'(pad_out), exp_dat(w_old));
        check("R4 pad_oe held while shifting", int'(pad_oe), exp_oe(w_old));
      end
      step(0, 0, 1, 0);
      check("R4 pad_out after strobe", int'(pad_out), exp_dat(w2));
      check("R4 pad_oe after strobe", int'(pad_oe), exp_oe(w2));
    end

    // R4: shift and update on the same edge, the update takes the pre-edge chain.
    begin
      int w3 = 5'b01011;
      for (int i = 0; i < 5; i++) step(1, 1, 0, w3[i]);
      step(1, 1, 1, 1'b0);
      check("R4 combined edge pad_out", int'(pad_out), exp_dat(w3));
      check("R4 combined edge pad_oe", int'(pad_oe), exp_oe(w3));
    end

    // R8: no DR clock means the chain holds despite shift select and scan_in activity.
    begin
      int w4 = 5'b01101;
      for (int i = 0; i < 5; i++) step(1, 1, 0, w4[i]);
      for (int i = 0; i < 6; i++) step(0, 1, 0, i[0]);
      step(0, 0, 1, 0);
      check("R8 pad_out after idle clocks", int'(pad_out), exp_dat(w4));
      check("R8 pad_oe after idle clocks", int'(pad_oe), exp_oe(w4));
      scan(0, got);
      // w4 shifted in bit0 first: scan order reads w4 back bit0 first.
      check("R8 chain contents kept", got, w4);
    end

    // R5 normal mode: pins follow the core.
    ext_test = 0;
    for (int c = 0; c < 16; c++) begin
      core_out = c[1:0]; core_oe = c[3:2];
      #1;
      check("R5 normal pad_out", int'(pad_out), c & 3);
      check("R5 normal pad_oe", int'(pad_oe), (c >> 2) & 3);
    end

    // R6 / R7 overrides in both modes. Update stages hold w4.
    core_out = 2'b10; core_oe = 2'b11;
    for (int m = 0; m < 2; m++) begin
      ext_test = m[0];
      force_hiz = 1; #1;
      check("R6 hiz pad_oe", int'(pad_oe), 0);
      check("R6 hiz pad_out kept", int'(pad_out), m == 1 ? exp_dat(5'b01101) : 2);
      force_hiz = 0; test_oe_n = 0; #1;
      check("R7 test_oe_n pad_oe", int'(pad_oe), 0);
      test_oe_n = 1; #1;
      check("R6 R7 released pad_oe", int'(pad_oe), m == 1 ? exp_oe(5'b01101) : 3);
    end

    // R1: reset in mid-run clears both stages.
    ext_test = 1;
    @(negedge clk);
    rst_n = 0; #1;
    check("R1 mid-run scan_out", int'(scan_out), 0);
    check("R1 mid-run pad_out", int'(pad_out), 0);
    check("R1 mid-run pad_oe", int'(pad_oe), 0);
    rst_n = 1;
    #3;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule